// File: doc/BRIEF.md
# Microsequencer Multi-Way Dispatch Unit

This block computes the next control-store address of a microprogrammed controller. Each microinstruction names a sequencing operation: step to the following word, jump, branch on a condition, call or return from a subroutine, or dispatch 32 ways or 16 ways on a 5-bit value. The dispatch value comes from one of four 5-bit sources: a literal in the microinstruction, the tag or flag field of a data register, or the tag of the word just read from memory. A condition-code bit is picked from a 32-bit vector. Both are captured when a sequencer cycle ends. They steer only the instruction that follows, so there is one pipeline stage between selecting a condition and acting on it.

A dispatch does not use the 5-bit value as an offset. The value, together with a page number from the microinstruction, addresses a writable translation RAM. The 8-bit word read from that RAM forms the upper part of the next address. The low 5 bits come straight from the microinstruction. Plain jumps, taken branches and calls use the same path with the index forced to zero, so each page keeps its target in entry zero. A host loads the RAM while the sequencer is halted. The sequencer takes one step every two clocks. The clock times the data ticks, and a phase output tells the data path which of the two data-control parts is active.

Top module: `useq_dispatch`

## Requirements
- R1: After reset, `upc` is 0, `tick_phase` is 0 and `stk_err` is 0.
- R2: While `run` is 1, `tick_phase` alternates 0,1,0,… from 0. A step happens on the clock edge where `tick_phase` is 1, and `upc` changes only on a step. While `run` is 0, `tick_phase` is 0 and `upc` holds.
- R3: `jsel` picks the dispatch source (0 literal `jconst`, 1 `g_tag`, 2 `g_flags`, 3 `mem_tag`), and `cc_vec[cc_sel]` is the condition bit. Both are latched on each step and used only by the next step's instruction.
- R4: For every translated target, the next address is {RAM[{`page`, index}], `lo_field`}, with the RAM word as bits 12:5.
- R5: `uop`=2 (32-way dispatch) uses the latched 5-bit dispatch value as the index.
- R6: `uop`=3 (16-way, lower half) forces index bit 4 to 0, and `uop`=4 (16-way, upper half) forces it to 1. Bits 3:0 come from the latched value.
- R7: `uop`=1 (jump) uses index 0.
- R8: `uop`=5 (conditional branch) goes to the index-0 target if the latched condition bit is 1. Otherwise it goes to `upc`+1.
- R9: `uop`=6 (call) pushes `upc`+1 and goes to the index-0 target. `uop`=7 (return) pops the most recent pushed address into `upc`.
- R10: The return stack holds 33 entries. A call with a full stack takes the jump, drops the push and sets `stk_err`. A return with an empty stack goes to `upc`+1 and sets `stk_err`. `stk_err` stays set until reset.
- R11: A host write (`host_we`) stores `host_data` at `host_addr` ({page, index}) only while `run` is 0. While `run` is 1 it is ignored.
- R12: `uop`=0 sets `upc` to `upc`+1 modulo 2^13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data-tick clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Sequencer enable; 0 halts it |
| uop | input | 3 | Sequencing operation of the current microinstruction |
| jsel | input | 2 | Dispatch source select |
| jconst | input | 5 | Literal dispatch value |
| page | input | PAGE_W (6) | Translation page number |
| lo_field | input | 5 | Low next-address bits |
| cc_sel | input | 5 | Condition-code bit select |
| g_tag | input | 5 | Tag field of the G register |
| g_flags | input | 5 | Flag field of the G register |
| mem_tag | input | 5 | Tag of the memory output word |
| cc_vec | input | 32 | Condition-code inputs |
| host_we | input | 1 | Translation RAM write strobe |
| host_addr | input | PAGE_W+5 (11) | Translation RAM write address {page, index} |
| host_data | input | 8 | Translation RAM write data |
| upc | output | 13 | Current microprogram address |
| tick_phase | output | 1 | 0 in the first data tick, 1 in the second |
| stk_err | output | 1 | Sticky stack overflow or underflow flag |

## Verification
Dispatch is driven from each of the four sources in turn, and every step also latches a new value. If the unit used the current value instead of the one latched a step earlier, the targets would differ. The two pages hold distinct values at every index, so a wrong page, a wrong index bit or a swapped source gives a distinct address. For 16-way dispatch, the latched values are chosen with the top bit opposite to the forced one, which separates forcing from passing the bit through. Calls are checked both nested and at exactly 33 and 34 levels deep, returns both with entries on the stack and with an empty stack, and a host write is attempted while running to confirm it is dropped.

// File: rtl/useq_pkg.sv
package useq_pkg;

  // Dispatch value width is fixed by 32-way branching on a 5-bit field.
  localparam int JW     = 5;
  localparam int JSRC_N = 4;

  typedef enum logic [2:0] {
    OP_INC     = 3'd0,
    OP_JMP     = 3'd1,
    OP_DISP32  = 3'd2,
    OP_DISP16L = 3'd3,
    OP_DISP16H = 3'd4,
    OP_BRCC    = 3'd5,
    OP_CALL    = 3'd6,
    OP_RET     = 3'd7
  } useq_op_e;

  typedef enum logic [1:0] {
    JS_CONST = 2'd0,
    JS_GTAG  = 2'd1,
    JS_GFLAG = 2'd2,
    JS_MTAG  = 2'd3
  } jsrc_e;

  // Index into the translation page for a given operation.
  function automatic logic [JW-1:0] xlat_index(useq_op_e op, logic [JW-1:0] jl);
    logic [JW-1:0] r;
    case (op)
      OP_DISP32:  r = jl;
      OP_DISP16L: r = {1'b0, jl[JW-2:0]};
      OP_DISP16H: r = {1'b1, jl[JW-2:0]};
      default:    r = '0;
    endcase
    return r;
  endfunction

  // Operations whose next address comes from the translation RAM.
  function automatic logic uses_xlat(useq_op_e op);
    return (op == OP_JMP) || (op == OP_DISP32) || (op == OP_DISP16L) ||
           (op == OP_DISP16H) || (op == OP_CALL);
  endfunction

endpackage

// File: rtl/useq_jsel.sv
module useq_jsel
  import useq_pkg::*;
#(
  parameter int CC_N     = 32,
  parameter int CC_SEL_W = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                latch_en,
  input  logic [1:0]          jsel,
  input  logic [JW-1:0]       jconst,
  input  logic [JW-1:0]       g_tag,
  input  logic [JW-1:0]       g_flags,
  input  logic [JW-1:0]       mem_tag,
  input  logic [CC_N-1:0]     cc_vec,
  input  logic [CC_SEL_W-1:0] cc_sel,
  output logic [JW-1:0]       j_lat,
  output logic                cc_lat
);

  logic [JW-1:0] src [JSRC_N];
  logic [JW-1:0] j_now;
  logic          cc_now;

  assign src[JS_CONST] = jconst;
  assign src[JS_GTAG]  = g_tag;
  assign src[JS_GFLAG] = g_flags;
  assign src[JS_MTAG]  = mem_tag;

  assign j_now  = src[jsel];
  assign cc_now = cc_vec[cc_sel];

  // One pipeline stage: values picked now steer the following instruction.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      j_lat  <= '0;
      cc_lat <= 1'b0;
    end else if (latch_en) begin
      j_lat  <= j_now;
      cc_lat <= cc_now;
    end
  end

endmodule

// File: rtl/useq_xlat_ram.sv
module useq_xlat_ram #(
  parameter int AW = 11,
  parameter int DW = 8,
  localparam int NWORDS = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [NWORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/useq_stack.sv
module useq_stack #(
  parameter int DEPTH = 33,
  parameter int W     = 13,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] cnt,
  output logic          ovf,
  output logic          unf
);

  logic [W-1:0] mem [DEPTH];
  logic         full;
  logic         empty;

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign ovf   = push && full;
  assign unf   = pop && empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (push && !full) begin
      cnt <= cnt + CW'(1);
    end else if (pop && !empty) begin
      cnt <= cnt - CW'(1);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && !full && (cnt == CW'(i))) mem[i] <= din;
    end
  end

  always_comb begin
    dout = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cnt == CW'(i + 1)) dout = mem[i];
    end
  end

endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
  import useq_pkg::*;
#(
  parameter int PAGE_W    = 6,
  parameter int XLAT_W    = 8,
  parameter int LO_W      = 5,
  parameter int STK_DEPTH = 33,
  parameter int CC_N      = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          run,
  input  logic [2:0]                    uop,
  input  logic [1:0]                    jsel,
  input  logic [4:0]                    jconst,
  input  logic [PAGE_W-1:0]             page,
  input  logic [LO_W-1:0]               lo_field,
  input  logic [$clog2(CC_N)-1:0]       cc_sel,
  input  logic [4:0]                    g_tag,
  input  logic [4:0]                    g_flags,
  input  logic [4:0]                    mem_tag,
  input  logic [CC_N-1:0]               cc_vec,
  input  logic                          host_we,
  input  logic [PAGE_W+4:0]             host_addr,
  input  logic [XLAT_W-1:0]             host_data,
  output logic [XLAT_W+LO_W-1:0]        upc,
  output logic                          tick_phase,
  output logic                          stk_err
);

  localparam int ADDR_W   = XLAT_W + LO_W;
  localparam int RAM_AW   = PAGE_W + JW;
  localparam int CC_SEL_W = $clog2(CC_N);
  localparam int STK_CW   = $clog2(STK_DEPTH + 1);

  useq_op_e           op;
  logic               step_evt;
  logic               push_evt;
  logic               pop_evt;
  logic [JW-1:0]      j_lat;
  logic               cc_lat;
  logic [JW-1:0]      xidx;
  logic [RAM_AW-1:0]  ram_raddr;
  logic [XLAT_W-1:0]  ram_rdata;
  logic               ram_we;
  logic [ADDR_W-1:0]  xlat_tgt;
  logic [ADDR_W-1:0]  upc_inc;
  logic [ADDR_W-1:0]  stk_top;
  logic [STK_CW-1:0]  stk_cnt;
  logic               stk_ovf;
  logic               stk_unf;
  logic [ADDR_W-1:0]  next_upc;

  assign op = useq_op_e'(uop);

  // Two data ticks per sequencer cycle.
  always_ff @(posedge clk) begin
    if (!rst_n)    tick_phase <= 1'b0;
    else if (!run) tick_phase <= 1'b0;
    else           tick_phase <= ~tick_phase;
  end

  assign step_evt = run && tick_phase;
  assign push_evt = step_evt && (op == OP_CALL);
  assign pop_evt  = step_evt && (op == OP_RET);

  useq_jsel #(
    .CC_N     (CC_N),
    .CC_SEL_W (CC_SEL_W)
  ) u_jsel (
    .clk      (clk),
    .rst_n    (rst_n),
    .latch_en (step_evt),
    .jsel     (jsel),
    .jconst   (jconst),
    .g_tag    (g_tag),
    .g_flags  (g_flags),
    .mem_tag  (mem_tag),
    .cc_vec   (cc_vec),
    .cc_sel   (cc_sel),
    .j_lat    (j_lat),
    .cc_lat   (cc_lat)
  );

  assign xidx      = xlat_index(op, j_lat);
  assign ram_raddr = {page, xidx};
  assign ram_we    = host_we && !run;

  useq_xlat_ram #(
    .AW (RAM_AW),
    .DW (XLAT_W)
  ) u_xlat (
    .clk   (clk),
    .we    (ram_we),
    .waddr (host_addr),
    .wdata (host_data),
    .raddr (ram_raddr),
    .rdata (ram_rdata)
  );

  assign xlat_tgt = {ram_rdata, lo_field};
  assign upc_inc  = upc + ADDR_W'(1);

  useq_stack #(
    .DEPTH (STK_DEPTH),
    .W     (ADDR_W)
  ) u_stack (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push_evt),
    .pop   (pop_evt),
    .din   (upc_inc),
    .dout  (stk_top),
    .cnt   (stk_cnt),
    .ovf   (stk_ovf),
    .unf   (stk_unf)
  );

  always_comb begin
    if (uses_xlat(op)) begin
      next_upc = xlat_tgt;
    end else begin
      case (op)
        OP_BRCC: next_upc = cc_lat ? xlat_tgt : upc_inc;
        OP_RET:  next_upc = stk_unf ? upc_inc : stk_top;
        default: next_upc = upc_inc;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        upc <= '0;
    else if (step_evt) upc <= next_upc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 stk_err <= 1'b0;
    else if (stk_ovf || stk_unf) stk_err <= 1'b1;
  end

endmodule

// File: rtl/useq_dispatch_chk.sv
module useq_dispatch_chk #(
  parameter int ADDR_W = 13,
  parameter int CW     = 6,
  parameter int DEPTH  = 33
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              tick_phase,
  input logic              step_evt,
  input logic              push_evt,
  input logic              pop_evt,
  input logic [2:0]        uop,
  input logic [ADDR_W-1:0] upc,
  input logic [CW-1:0]     stk_cnt,
  input logic              stk_ovf,
  input logic              stk_unf,
  input logic              stk_err
);

  // R2
  upc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_evt |=> $stable(upc));

  // R2
  phase_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick_phase) |=> tick_phase);

  // R12
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && uop == 3'd0) |=> (upc == $past(upc) + ADDR_W'(1)));

  // R9
  push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_evt && !stk_ovf) |=> (stk_cnt == $past(stk_cnt) + CW'(1)));

  // R9
  pop_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_evt && !stk_unf) |=> (stk_cnt == $past(stk_cnt) - CW'(1)));

  // R10
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stk_cnt <= CW'(DEPTH));

  // R10
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_ovf || stk_unf) |=> stk_err);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stk_err |=> stk_err);

endmodule

bind useq_dispatch useq_dispatch_chk #(
  .ADDR_W (ADDR_W),
  .CW     (STK_CW),
  .DEPTH  (STK_DEPTH)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run),
  .tick_phase (tick_phase),
  .step_evt   (step_evt),
  .push_evt   (push_evt),
  .pop_evt    (pop_evt),
  .uop        (uop),
  .upc        (upc),
  .stk_cnt    (stk_cnt),
  .stk_ovf    (stk_ovf),
  .stk_unf    (stk_unf),
  .stk_err    (stk_err)
);

// File: tb/tb_useq_dispatch.sv
module tb_useq_dispatch;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        run;
  logic [2:0]  uop;
  logic [1:0]  jsel;
  logic [4:0]  jconst;
  logic [5:0]  page;
  logic [4:0]  lo_field;
  logic [4:0]  cc_sel;
  logic [4:0]  g_tag;
  logic [4:0]  g_flags;
  logic [4:0]  mem_tag;
  logic [31:0] cc_vec;
  logic        host_we;
  logic [10:0] host_addr;
  logic [7:0]  host_data;
  logic [12:0] upc;
  logic        tick_phase;
  logic        stk_err;

  int checks = 0;
  int errors = 0;

  // Independent model state
  logic [7:0]  ram_m [2048];
  logic [12:0] m_upc;
  logic [4:0]  m_j;
  logic        m_cc;
  logic [12:0] m_stk [33];
  int          m_sp;
  logic        m_err;

  always #5 clk = ~clk;

  useq_dispatch dut (
    .clk(clk), .rst_n(rst_n), .run(run), .uop(uop), .jsel(jsel),
    .jconst(jconst), .page(page), .lo_field(lo_field), .cc_sel(cc_sel),
    .g_tag(g_tag), .g_flags(g_flags), .mem_tag(mem_tag), .cc_vec(cc_vec),
    .host_we(host_we), .host_addr(host_addr), .host_data(host_data),
    .upc(upc), .tick_phase(tick_phase), .stk_err(stk_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; run = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_upc = '0; m_j = '0; m_cc = 1'b0; m_sp = 0; m_err = 1'b0;
  endtask

  task automatic host_write(input logic [5:0] pg, input logic [4:0] ix, input logic [7:0] d);
    host_we = 1'b1; host_addr = {pg, ix}; host_data = d;
    if (!run) ram_m[{pg, ix}] = d;
    @(posedge clk); @(negedge clk);
    host_we = 1'b0;
  endtask

  // One sequencer cycle; called at a negedge with run=1 and tick_phase=0.
  task automatic do_step(input logic [2:0] op, input logic [1:0] js, input logic [4:0] jc,
                         input logic [5:0] pg, input logic [4:0] lo, input string req);
    logic [4:0]  idx;
    logic [12:0] tgt, ex, old;
    old = m_upc;
    case (op)
      3'd2:    idx = m_j;
      3'd3:    idx = m_j & 5'h0F;
      3'd4:    idx = m_j | 5'h10;
      default: idx = 5'd0;
    endcase
    tgt = {ram_m[{pg, idx}], lo};
    case (op)
      3'd0: ex = old + 13'd1;
      3'd5: ex = m_cc ? tgt : old + 13'd1;
      3'd6: begin
        ex = tgt;
        if (m_sp < 33) begin m_stk[m_sp] = old + 13'd1; m_sp++; end
        else m_err = 1'b1;
      end
      3'd7: begin
        if (m_sp == 0) begin ex = old + 13'd1; m_err = 1'b1; end
        else begin m_sp--; ex = m_stk[m_sp]; end
      end
      default: ex = tgt;
    endcase
    case (js)
      2'd0:    m_j = jc;
      2'd1:    m_j = g_tag;
      2'd2:    m_j = g_flags;
      default: m_j = mem_tag;
    endcase
    m_cc = cc_vec[cc_sel];
    uop = op; jsel = js; jconst = jc; page = pg; lo_field = lo;
    @(posedge clk); @(negedge clk);
    chk(upc == old, "R2", "upc mid-cycle", upc, old);
    chk(tick_phase == 1'b1, "R2", "phase second tick", tick_phase, 1);
    @(posedge clk); @(negedge clk);
    chk(upc == ex, req, "upc after step", upc, ex);
    chk(stk_err == m_err, "R10", "stk_err", stk_err, m_err);
    chk(tick_phase == 1'b0, "R2", "phase first tick", tick_phase, 0);
    m_upc = ex;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk(upc == 13'd0, "R1", "upc reset", upc, 0);
    chk(tick_phase == 1'b0, "R1", "phase reset", tick_phase, 0);
    chk(stk_err == 1'b0, "R1", "err reset", stk_err, 0);
  endtask

  task automatic t_load();
    run = 1'b0;
    host_write(6'd1, 5'd0, 8'h12);
    host_write(6'd2, 5'd0, 8'h33);
    host_write(6'd3, 5'd0, 8'h05);
    for (int i = 1; i < 32; i++) begin
      host_write(6'd1, 5'(i), 8'(8'h40 + i));
      host_write(6'd2, 5'(i), 8'(8'h80 + i));
    end
    @(negedge clk);
    run = 1'b1;
  endtask

  task automatic t_increment();
    do_step(3'd0, 2'd0, 5'd0, 6'd0, 5'd0, "R12");
    do_step(3'd0, 2'd0, 5'd0, 6'd0, 5'd0, "R12");
    do_step(3'd0, 2'd0, 5'd0, 6'd0, 5'd0, "R12");
  endtask

  task automatic t_jump_and_host_gate();
    // R11: write attempted during run; model leaves entry unchanged
    host_we = 1'b1; host_addr = {6'd1, 5'd0}; host_data = 8'hEE;
    do_step(3'd0, 2'd0, 5'd0, 6'd0, 5'd0, "R11");
    host_we = 1'b0;
    do_step(3'd1, 2'd0, 5'd0, 6'd1, 5'd3, "R11");
    chk(upc == {8'h12, 5'd3}, "R7", "jump through index 0", upc, {8'h12, 5'd3});
  endtask

  task automatic t_sources();
    g_tag = 5'h0B; g_flags = 5'h1C; mem_tag = 5'h13;
    do_step(3'd0, 2'd0, 5'd7, 6'd0, 5'd0, "R3");
    do_step(3'd2, 2'd1, 5'd0, 6'd1, 5'd1, "R5");
    chk(upc == {8'h47, 5'd1}, "R4", "literal source dispatch", upc, {8'h47, 5'd1});
    do_step(3'd2, 2'd2, 5'd0, 6'd2, 5'd2, "R3");
    chk(upc == {8'h8B, 5'd2}, "R3", "g_tag source", upc, {8'h8B, 5'd2});
    do_step(3'd2, 2'd3, 5'd0, 6'd1, 5'd4, "R3");
    chk(upc == {8'h5C, 5'd4}, "R3", "g_flags source", upc, {8'h5C, 5'd4});
    do_step(3'd2, 2'd0, 5'd0, 6'd2, 5'd5, "R3");
    chk(upc == {8'h93, 5'd5}, "R3", "mem_tag source", upc, {8'h93, 5'd5});
  endtask

  task automatic t_half_dispatch();
    do_step(3'd0, 2'd0, 5'h1A, 6'd0, 5'd0, "R12");
    do_step(3'd3, 2'd0, 5'h05, 6'd1, 5'd6, "R6");
    chk(upc == {8'h4A, 5'd6}, "R6", "16-way low forces bit4=0", upc, {8'h4A, 5'd6});
    do_step(3'd4, 2'd0, 5'd0, 6'd2, 5'd7, "R6");
    chk(upc == {8'h95, 5'd7}, "R6", "16-way high forces bit4=1", upc, {8'h95, 5'd7});
  endtask

  task automatic t_branch();
    cc_vec = 32'h0000_0010; cc_sel = 5'd4;
    do_step(3'd0, 2'd0, 5'd0, 6'd0, 5'd0, "R3");
    cc_sel = 5'd9;
    do_step(3'd5, 2'd0, 5'd0, 6'd1, 5'd2, "R8");
    chk(upc == {8'h12, 5'd2}, "R8", "branch taken", upc, {8'h12, 5'd2});
    do_step(3'd5, 2'd0, 5'd0, 6'd1, 5'd2, "R8");
  endtask

  task automatic t_calls();
    do_step(3'd6, 2'd0, 5'd0, 6'd3, 5'd0, "R9");
    do_step(3'd0, 2'd0, 5'd0, 6'd0, 5'd0, "R12");
    do_step(3'd6, 2'd0, 5'd0, 6'd3, 5'd4, "R9");
    do_step(3'd7, 2'd0, 5'd0, 6'd0, 5'd0, "R9");
    do_step(3'd7, 2'd0, 5'd0, 6'd0, 5'd0, "R9");
  endtask

  task automatic t_halt();
    logic [12:0] held;
    held = upc;
    run = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(upc == held, "R2", "upc held while halted", upc, held);
    chk(tick_phase == 1'b0, "R2", "phase while halted", tick_phase, 0);
    run = 1'b1;
  endtask

  task automatic t_underflow();
    do_reset();
    run = 1'b1;
    do_step(3'd7, 2'd0, 5'd0, 6'd0, 5'd0, "R10");
    chk(stk_err == 1'b1, "R10", "underflow sets err", stk_err, 1);
  endtask

  task automatic t_overflow();
    do_reset();
    run = 1'b1;
    for (int i = 0; i < 33; i++) do_step(3'd6, 2'd0, 5'd0, 6'd3, 5'(i), "R9");
    chk(stk_err == 1'b0, "R10", "33 calls fit", stk_err, 0);
    do_step(3'd6, 2'd0, 5'd0, 6'd1, 5'd9, "R10");
    chk(stk_err == 1'b1, "R10", "34th call overflows", stk_err, 1);
    for (int i = 0; i < 33; i++) do_step(3'd7, 2'd0, 5'd0, 6'd0, 5'd0, "R9");
    do_step(3'd7, 2'd0, 5'd0, 6'd0, 5'd0, "R10");
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0; run = 1'b0; uop = '0; jsel = '0; jconst = '0; page = '0;
    lo_field = '0; cc_sel = '0; g_tag = '0; g_flags = '0; mem_tag = '0;
    cc_vec = '0; host_we = 1'b0; host_addr = '0; host_data = '0;
    t_reset_state();
    t_load();
    t_increment();
    t_jump_and_host_gate();
    t_sources();
    t_half_dispatch();
    t_branch();
    t_calls();
    t_halt();
    t_underflow();
    t_overflow();
    summary();
  end

endmodule